// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit turns a decoded addressing request into the final operand address for a processor with 16-bit addresses and byte-wide memory. The caller presents a mode code, a base-register code, a step field, a 16-bit operand field, the two 8-bit accumulators and the current X, Y, SP and PC values. The caller then pulses `start`. Plain forms finish one cycle later. The two indirect forms first compute a pointer location and then read a big-endian word through a synchronous byte read port. That word becomes the address.

Auto-adjust forms also produce a writeback: an enable, the code of the base register to update and its new value. The register file stays outside the unit. An auto-adjust request with PC as the base is refused on `err`, and so is any unassigned mode code.

Top module: `idx_ea_unit`

## Requirements
- R1: Mode code 0 (short absolute) gives `ea` = {8'h00, operand[7:0]}, so the result always lies in 0x0000..0x00FF.
- R2: Mode code 1 (long absolute) gives `ea` = operand.
- R3: Mode codes 2, 3 and 4 add to the base the sign-extended operand[4:0], the sign-extended operand[8:0] and the full operand, in that order, modulo 2^16. Base codes are 0 X, 1 Y, 2 SP and 3 PC. The PC base is `pc_in` as sampled at the `start` edge.
- R4: Mode code 5 adds an accumulator to the base, modulo 2^16. `acc_sel` 0 selects A and 1 selects B, each zero-extended. `acc_sel` 2 or 3 selects D = {A, B}.
- R5: Mode codes 6 (step up) and 7 (step down) adjust the base by n = `step`+1 (1..8) before use. Both `ea` and `wb_val` equal the adjusted value, `wb_en` pulses with `done`, and `wb_sel` equals the base code.
- R6: Mode codes 8 (step up) and 9 (step down) use the unmodified base as `ea`. `wb_val` is the base adjusted by `step`+1, with `wb_en` and `wb_sel` as in R5.
- R7: Modes 6..9 with base code 3, and every mode code from 12 to 15, complete with `done` and `err` high, `wb_en` low and `ea` = 0.
- R8: Mode codes 10 (base + operand) and 11 (base + D) form a pointer P modulo 2^16. The unit reads P in the first busy cycle and P+1 in the second, with `mem_rd` high and `mem_addr` driven. `mem_rdata` must return each byte one cycle after its request. In the cycle after the third busy cycle, `done` rises with `ea` = {byte at P, byte at P+1}. Any P is allowed, odd values included.
- R9: `start` is ignored while `busy` is high.
- R10: After reset `busy`, `done`, `err`, `wb_en` and `mem_rd` are low and `ea` is 0.
- R11: A non-indirect request accepted at a clock edge raises `done` for exactly the following cycle. `ea` then holds until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when not busy |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 2 | Base register code (X, Y, SP, PC) |
| acc_sel | input | 2 | Accumulator choice for mode 5 |
| step | input | 3 | Adjust amount minus one |
| operand | input | 16 | Constant, offset or absolute operand field |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| x_in | input | 16 | Current X |
| y_in | input | 16 | Current Y |
| sp_in | input | 16 | Current SP |
| pc_in | input | 16 | Current PC |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| mem_rd | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte address |
| busy | output | 1 | Indirect fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal request, valid with done |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base register writeback strobe |
| wb_sel | output | 2 | Register code to write back |
| wb_val | output | 16 | Writeback value |

## Verification
The bench targets negative short and medium offsets, whose sign bit a zero-extending design would drop. It also targets sums that cross 0xFFFF, which expose missing wraparound. Accumulator A with its top bit set catches a design that sign-extends the 8-bit accumulators. Step values 1 and 8, in both pre- and post-adjust form, separate returning the adjusted value from returning the original one, and would catch a step encoding that is off by one. Indirect fetches from odd pointers, whose word straddles a 256-byte page, detect swapped byte order or a missing increment. Holding `start` high through a fetch, and issuing a refused PC-based adjust, expose a unit that accepts work while busy or that writes back on error.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    typedef enum logic [3:0] {
        MD_ABS8    = 4'd0,
        MD_ABS16   = 4'd1,
        MD_OFS_S   = 4'd2,
        MD_OFS_M   = 4'd3,
        MD_OFS_L   = 4'd4,
        MD_ACC     = 4'd5,
        MD_PRE_UP  = 4'd6,
        MD_PRE_DN  = 4'd7,
        MD_POST_UP = 4'd8,
        MD_POST_DN = 4'd9,
        MD_IND_K   = 4'd10,
        MD_IND_D   = 4'd11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD_HI = 2'd1,
        ST_RD_LO = 2'd2,
        ST_FIN  = 2'd3
    } state_e;

    localparam logic [1:0] BASE_PC = 2'd3;

endpackage

// File: rtl/idx_ea_base_mux.sv
module idx_ea_base_mux #(
    parameter int AW = 16
) (
    input  logic [1:0]    base_sel,
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] y_in,
    input  logic [AW-1:0] sp_in,
    input  logic [AW-1:0] pc_in,
    output logic [AW-1:0] base,
    output logic          base_is_pc
);
    localparam int NREG = 4;

    logic [AW-1:0] regs [NREG];

    assign regs[0] = x_in;
    assign regs[1] = y_in;
    assign regs[2] = sp_in;
    assign regs[3] = pc_in;

    assign base       = regs[base_sel];
    assign base_is_pc = (base_sel == idx_ea_pkg::BASE_PC);
endmodule

// File: rtl/idx_ea_addend.sv
module idx_ea_addend #(
    parameter int AW    = 16,
    parameter int BW    = 8,
    parameter int OFS_S = 5,
    parameter int OFS_M = 9
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    acc_sel,
    input  logic [AW-1:0] operand,
    input  logic [BW-1:0] acc_a,
    input  logic [BW-1:0] acc_b,
    output logic [AW-1:0] addend
);
    import idx_ea_pkg::*;

    localparam int NSX = 2;

    logic [AW-1:0] sx [NSX];
    logic [AW-1:0] acc_ext;

    // Sign-extended short and medium constants.
    for (genvar g = 0; g < NSX; g++) begin : g_sext
        localparam int W = (g == 0) ? OFS_S : OFS_M;
        assign sx[g] = {{(AW-W){operand[W-1]}}, operand[W-1:0]};
    end

    always_comb begin
        unique case (acc_sel)
            2'd0:    acc_ext = {{(AW-BW){1'b0}}, acc_a};
            2'd1:    acc_ext = {{(AW-BW){1'b0}}, acc_b};
            default: acc_ext = {acc_a, acc_b};
        endcase
    end

    always_comb begin
        unique case (mode)
            MD_OFS_S: addend = sx[0];
            MD_OFS_M: addend = sx[1];
            MD_OFS_L: addend = operand;
            MD_IND_K: addend = operand;
            MD_ACC:   addend = acc_ext;
            MD_IND_D: addend = {acc_a, acc_b};
            default:  addend = '0;
        endcase
    end
endmodule

// File: rtl/idx_ea_adjust.sv
module idx_ea_adjust #(
    parameter int AW = 16,
    parameter int SW = 3
) (
    input  logic [AW-1:0] base,
    input  logic [SW-1:0] step,
    input  logic          down,
    output logic [AW-1:0] adjusted
);
    logic [AW-1:0] amount;

    assign amount   = AW'(step) + AW'(1);
    assign adjusted = down ? (base - amount) : (base + amount);
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit #(
    parameter int AW = 16,
    parameter int SW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [3:0]         mode,
    input  logic [1:0]         base_sel,
    input  logic [1:0]         acc_sel,
    input  logic [SW-1:0]      step,
    input  logic [AW-1:0]      operand,
    input  logic [AW/2-1:0]    acc_a,
    input  logic [AW/2-1:0]    acc_b,
    input  logic [AW-1:0]      x_in,
    input  logic [AW-1:0]      y_in,
    input  logic [AW-1:0]      sp_in,
    input  logic [AW-1:0]      pc_in,
    input  logic [AW/2-1:0]    mem_rdata,
    output logic               mem_rd,
    output logic [AW-1:0]      mem_addr,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [AW-1:0]      ea,
    output logic               wb_en,
    output logic [1:0]         wb_sel,
    output logic [AW-1:0]      wb_val
);
    import idx_ea_pkg::*;

    localparam int BW = AW / 2;

    typedef struct packed {
        state_e        state;
        logic [AW-1:0] ptr;
        logic [BW-1:0] hi;
        logic [AW-1:0] ea;
        logic          done;
        logic          err;
        logic          wb_en;
        logic [1:0]    wb_sel;
        logic [AW-1:0] wb_val;
    } regs_t;

    regs_t r_d, r_q;

    logic [AW-1:0] base;
    logic          base_is_pc;
    logic [AW-1:0] addend;
    logic [AW-1:0] sum;
    logic [AW-1:0] adjusted;
    logic          step_down;

    idx_ea_base_mux #(.AW(AW)) u_base (
        .base_sel   (base_sel),
        .x_in       (x_in),
        .y_in       (y_in),
        .sp_in      (sp_in),
        .pc_in      (pc_in),
        .base       (base),
        .base_is_pc (base_is_pc)
    );

    idx_ea_addend #(.AW(AW), .BW(BW)) u_addend (
        .mode    (mode),
        .acc_sel (acc_sel),
        .operand (operand),
        .acc_a   (acc_a),
        .acc_b   (acc_b),
        .addend  (addend)
    );

    assign step_down = (mode == MD_PRE_DN) || (mode == MD_POST_DN);

    idx_ea_adjust #(.AW(AW), .SW(SW)) u_adjust (
        .base     (base),
        .step     (step),
        .down     (step_down),
        .adjusted (adjusted)
    );

    assign sum = base + addend;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        r_d.wb_en  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.done = 1'b1;
                    unique case (mode)
                        MD_ABS8: r_d.ea = {{(AW-BW){1'b0}}, operand[BW-1:0]};
                        MD_ABS16: r_d.ea = operand;
                        MD_OFS_S, MD_OFS_M, MD_OFS_L, MD_ACC: r_d.ea = sum;
                        MD_PRE_UP, MD_PRE_DN, MD_POST_UP, MD_POST_DN: begin
                            if (base_is_pc) begin
                                r_d.err = 1'b1;
                                r_d.ea  = '0;
                            end else begin
                                r_d.wb_en  = 1'b1;
                                r_d.wb_sel = base_sel;
                                r_d.wb_val = adjusted;
                                r_d.ea = ((mode == MD_PRE_UP) || (mode == MD_PRE_DN))
                                         ? adjusted : base;
                            end
                        end
                        MD_IND_K, MD_IND_D: begin
                            r_d.done  = 1'b0;
                            r_d.ptr   = sum;
                            r_d.state = ST_RD_HI;
                        end
                        default: begin
                            r_d.err = 1'b1;
                            r_d.ea  = '0;
                        end
                    endcase
                end
            end
            ST_RD_HI: r_d.state = ST_RD_LO;
            ST_RD_LO: begin
                r_d.hi    = mem_rdata;
                r_d.state = ST_FIN;
            end
            default: begin
                r_d.ea    = {r_q.hi, mem_rdata};
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd   = (r_q.state == ST_RD_HI) || (r_q.state == ST_RD_LO);
    assign mem_addr = (r_q.state == ST_RD_LO) ? (r_q.ptr + AW'(1)) : r_q.ptr;
    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign ea       = r_q.ea;
    assign wb_en    = r_q.wb_en;
    assign wb_sel   = r_q.wb_sel;
    assign wb_val   = r_q.wb_val;
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic [1:0]    base_sel,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] ea,
    input logic          wb_en,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr
);
    AST_ABS8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd0) |=> (done && ea[AW-1:8] == '0)); // R1

    AST_PC_ADJUST_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && base_sel == 2'd3 && mode >= 4'd6 && mode <= 4'd9)
        |=> (err && !wb_en)); // R7

    AST_ERR_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !wb_en)); // R7

    AST_SECOND_READ_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R8

    AST_READ_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy); // R8

    AST_INDIRECT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (mode == 4'd10 || mode == 4'd11)) |=> (busy && mem_rd && !done)); // R8

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R9

    AST_PLAIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != 4'd10 && mode != 4'd11) |=> (done && !busy)); // R11
endmodule

bind idx_ea_unit idx_ea_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .base_sel (base_sel),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .ea       (ea),
    .wb_en    (wb_en),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
);

// File: tb/idx_ea_unit_test.sv
module idx_ea_unit_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  base_sel = '0;
    logic [1:0]  acc_sel = '0;
    logic [2:0]  step = '0;
    logic [15:0] operand = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic [15:0] x_in = '0, y_in = '0, sp_in = '0, pc_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rd, busy, done, err, wb_en;
    logic [15:0] mem_addr, ea, wb_val;
    logic [1:0]  wb_sel;

    int checks = 0;
    int fails = 0;
    string tag = "R10";

    idx_ea_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_sel(base_sel),
        .acc_sel(acc_sel), .step(step), .operand(operand), .acc_a(acc_a), .acc_b(acc_b),
        .x_in(x_in), .y_in(y_in), .sp_in(sp_in), .pc_in(pc_in), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy), .done(done), .err(err),
        .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] memf(logic [15:0] a);
        return (a[15:8] ^ {a[6:0], a[7]}) + 8'h3C;
    endfunction

    // Synchronous byte memory: data one cycle after the request.
    always @(posedge clk) if (mem_rd) mem_rdata <= memf(mem_addr);

    // Behavioural reference model.
    int          phase = 0;
    logic [15:0] m_ptr = '0, m_ea = '0, m_wbv = '0;
    logic        m_done = 0, m_err = 0, m_wb = 0;
    logic [1:0]  m_wbs = '0;

    task automatic model_start();
        int b, r, n;
        case (base_sel)
            2'd0: b = x_in;
            2'd1: b = y_in;
            2'd2: b = sp_in;
            default: b = pc_in;
        endcase
        n = step + 1;
        m_done = 1;
        case (mode)
            4'd0: m_ea = operand % 256;
            4'd1: m_ea = operand;
            4'd2: begin r = operand[4:0]; if (r >= 16) r -= 32; m_ea = 16'(b + r); end
            4'd3: begin r = operand[8:0]; if (r >= 256) r -= 512; m_ea = 16'(b + r); end
            4'd4: m_ea = 16'(b + operand);
            4'd5: begin
                if (acc_sel == 0) r = acc_a;
                else if (acc_sel == 1) r = acc_b;
                else r = acc_a * 256 + acc_b;
                m_ea = 16'(b + r);
            end
            4'd6, 4'd7, 4'd8, 4'd9: begin
                if (base_sel == 3) begin m_err = 1; m_ea = 0; end
                else begin
                    r = (mode == 7 || mode == 9) ? b - n : b + n;
                    m_wb = 1; m_wbs = base_sel; m_wbv = 16'(r);
                    m_ea = (mode <= 7) ? 16'(r) : 16'(b);
                end
            end
            4'd10: begin m_done = 0; m_ptr = 16'(b + operand); phase = 3; end
            4'd11: begin m_done = 0; m_ptr = 16'(b + acc_a * 256 + acc_b); phase = 3; end
            default: begin m_err = 1; m_ea = 0; end
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; m_ea = 0; m_done = 0; m_err = 0; m_wb = 0;
        end else begin
            m_done = 0; m_err = 0; m_wb = 0;
            if (phase > 0) begin
                phase--;
                if (phase == 0) begin
                    m_done = 1;
                    m_ea = {memf(m_ptr), memf(16'(m_ptr + 1))};
                end
            end else if (start) begin
                model_start();
            end
        end
    end

    task automatic chk(string nm, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    // Compare on every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("busy", busy, phase > 0);
            chk("done", done, m_done);
            chk("err", err, m_err);
            chk("wb_en", wb_en, m_wb);
            chk("ea", ea, m_ea);
            chk("mem_rd", mem_rd, phase == 3 || phase == 2);
            if (phase == 3) chk("mem_addr", mem_addr, m_ptr);
            if (phase == 2) chk("mem_addr", mem_addr, 16'(m_ptr + 1));
            if (m_wb) begin
                chk("wb_sel", wb_sel, m_wbs);
                chk("wb_val", wb_val, m_wbv);
            end
        end
    end

    task automatic op(string t, logic [3:0] md, logic [1:0] bs, logic [1:0] as,
                      logic [2:0] st, logic [15:0] opd, int hold);
        tag = t;
        mode = md; base_sel = bs; acc_sel = as; step = st; operand = opd;
        start = 1'b1;
        repeat (hold) @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 50000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        tag = "R10";
        chk("busy", busy, 0); chk("done", done, 0); chk("err", err, 0);
        chk("wb_en", wb_en, 0); chk("mem_rd", mem_rd, 0); chk("ea", ea, 0);
        rst_n = 1'b1;
        @(negedge clk);

        x_in = 16'h0005; y_in = 16'h1234; sp_in = 16'h2FF0; pc_in = 16'hC000;
        acc_a = 8'hF0; acc_b = 8'h81;

        op("R1", 4'd0, 2'd0, 2'd0, 3'd0, 16'hABCD, 1);
        op("R2", 4'd1, 2'd0, 2'd0, 3'd0, 16'hABCD, 1);
        op("R3", 4'd2, 2'd0, 2'd0, 3'd0, 16'h0010, 1);  // -16 from X, wraps
        op("R3", 4'd2, 2'd3, 2'd0, 3'd0, 16'h000F, 1);  // +15 from PC
        op("R3", 4'd3, 2'd1, 2'd0, 3'd0, 16'h01FF, 1);  // -1 from Y
        op("R3", 4'd3, 2'd2, 2'd0, 3'd0, 16'h00FF, 1);
        op("R3", 4'd4, 2'd2, 2'd0, 3'd0, 16'hF000, 1);  // wraps past 0xFFFF
        pc_in = 16'h7FFE;
        op("R3", 4'd4, 2'd3, 2'd0, 3'd0, 16'h0004, 1);
        op("R4", 4'd5, 2'd0, 2'd0, 3'd0, 16'h0000, 1);  // A zero-extended
        op("R4", 4'd5, 2'd1, 2'd1, 3'd0, 16'h0000, 1);
        op("R4", 4'd5, 2'd2, 2'd2, 3'd0, 16'h0000, 1);
        op("R4", 4'd5, 2'd3, 2'd3, 3'd0, 16'h0000, 1);
        op("R5", 4'd6, 2'd0, 2'd0, 3'd0, 16'h0000, 1);
        op("R5", 4'd7, 2'd0, 2'd0, 3'd7, 16'h0000, 1);  // 5 - 8 wraps
        op("R5", 4'd6, 2'd2, 2'd0, 3'd7, 16'h0000, 1);
        op("R6", 4'd8, 2'd1, 2'd0, 3'd7, 16'h0000, 1);
        op("R6", 4'd9, 2'd2, 2'd0, 3'd0, 16'h0000, 1);
        op("R7", 4'd6, 2'd3, 2'd0, 3'd2, 16'h0000, 1);
        op("R7", 4'd9, 2'd3, 2'd0, 3'd0, 16'h0000, 1);
        op("R7", 4'd15, 2'd0, 2'd0, 3'd0, 16'h0000, 1);
        op("R7", 4'd12, 2'd1, 2'd0, 3'd0, 16'h0000, 1);
        op("R8", 4'd10, 2'd1, 2'd0, 3'd0, 16'h00CB, 1); // odd pointer 0x12FF
        op("R8", 4'd11, 2'd0, 2'd0, 3'd0, 16'h0000, 1); // X + D
        op("R8", 4'd10, 2'd3, 2'd0, 3'd0, 16'h8001, 1); // wraps to 0xFFFF
        // R9: start held high through the fetch with another mode presented
        tag = "R9";
        mode = 4'd10; base_sel = 2'd2; operand = 16'h0101;
        start = 1'b1;
        @(negedge clk);
        mode = 4'd1; operand = 16'h5555;
        repeat (2) @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        // R11: back-to-back plain requests
        op("R11", 4'd1, 2'd0, 2'd0, 3'd0, 16'h4242, 3);
        op("R11", 4'd0, 2'd0, 2'd0, 3'd0, 16'h1177, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule